// File: doc/BRIEF.md
# Frame Receive Buffer with Commit/Abort

This block is the receive-side word store of a CAN FD controller. The protocol engine writes a frame into it while the frame is still on the bus. One pulse stores the two metadata words: a format word and an identifier word. Further pulses each store one 32-bit payload word. Upstream logic has already packed the payload bytes, first byte in the top lane. A payload that ends part-way through a word arrives as one last pulse with zero low bytes.

Stores advance a speculative (raw) write pointer. The reader only sees words up to a separate committed write pointer. A commit pulse at the end of a good frame moves the committed pointer up to the raw one, so the whole frame becomes readable in one step. An abort pulse raised by an error frame pulls the raw pointer back, which discards the partial frame.

The free space is measured against the raw pointer, so a frame being written can never overwrite unread data. A store that does not fit is dropped. It sets a sticky overrun flag and spoils the frame, and the next commit of that frame behaves as an abort. The reader sees the word at the read pointer and advances it with a read strobe.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset the raw, committed and read positions are 0, free_words equals DEPTH, pending_words is 0, rd_valid is 0 and overrun is 0.
- R2: A meta_store pulse writes the format word at the raw position and the identifier word (bits 28:0 = ident, rest 0) at raw+1, and it advances the raw position by 2. The format word has dlc in bits 3:0, rtr in bit 4, extended-identifier in bit 5, FD in bit 6, bit-rate-switch in bit 7, error-state in bit 8, and zero above. The stored words are not visible to the reader before a commit.
- R3: A data_store pulse writes data_word at the raw position and advances the raw position by 1.
- R4: A frame_commit pulse on an unspoiled frame copies the raw position into the committed position. pending_words then counts the whole frame, and rd_valid rises if it was 0.
- R5: A frame_abort pulse returns the raw position to the committed position and leaves the committed position unchanged. Abort takes priority over a commit in the same cycle.
- R6: free_words equals DEPTH minus (raw - read) words, and pending_words equals (committed - read) words.
- R7: A store pulse that needs more words than free_words has writes nothing and leaves the raw position unchanged. It sets overrun, which stays set until reset. The next commit of that frame acts as an abort. The frame after it commits normally.
- R8: A read strobe advances the read position by one word only while pending_words is nonzero; with nothing pending it has no effect.
- R9: All positions wrap modulo DEPTH, so a frame may straddle the end of the storage.
- R10: In a cycle that also carries commit or abort, a store pulse is ignored. In a cycle that carries both meta_store and data_store, the data pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meta_store | input | 1 | Store the two metadata words |
| dlc | input | 4 | Data length code |
| rtr | input | 1 | Remote frame flag |
| ext_id | input | 1 | Extended identifier flag |
| fd_frame | input | 1 | FD frame flag |
| brs | input | 1 | Bit-rate switch flag |
| esi | input | 1 | Error state flag |
| ident | input | 29 | Frame identifier |
| data_store | input | 1 | Store one payload word |
| data_word | input | 32 | Payload word |
| frame_commit | input | 1 | Publish the stored frame |
| frame_abort | input | 1 | Discard the stored frame |
| rd_strobe | input | 1 | Advance the read position |
| rd_word | output | 32 | Word at the read position |
| rd_valid | output | 1 | Committed data is pending |
| free_words | output | $clog2(DEPTH)+1 | Free words relative to the raw position |
| pending_words | output | $clog2(DEPTH)+1 | Committed, unread words |
| raw_pos | output | $clog2(DEPTH) | Raw write position |
| commit_pos | output | $clog2(DEPTH) | Committed write position |
| read_pos | output | $clog2(DEPTH) | Read position |
| overrun | output | 1 | Sticky data-overrun flag |

## Verification
The bound checker checks several rules on every cycle. Counts stay within the depth. An abort lands the raw position on the committed one. A clean commit copies the raw position. Reads move only while data is pending. The overrun flag never clears by itself. Only the bench scenarios can show the stored contents and layout, the wrap across the end of storage, the suppression of colliding pulses, and that a spoiled commit discards the frame while the next frame commits normally.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_META,
      OP_DATA,
      OP_COMMIT,
      OP_ABORT
   } rxb_op_e;

   localparam int FMT_DLC_LSB = 0;
   localparam int FMT_RTR_BIT = 4;
   localparam int FMT_EXT_BIT = 5;
   localparam int FMT_FD_BIT  = 6;
   localparam int FMT_BRS_BIT = 7;
   localparam int FMT_ESI_BIT = 8;

   function automatic logic [31:0] pack_format(
      input logic [3:0] dlc_v,
      input logic       rtr_v,
      input logic       ext_v,
      input logic       fd_v,
      input logic       brs_v,
      input logic       esi_v);
      logic [31:0] w;
      w = '0;
      w[FMT_DLC_LSB +: 4] = dlc_v;
      w[FMT_RTR_BIT]      = rtr_v;
      w[FMT_EXT_BIT]      = ext_v;
      w[FMT_FD_BIT]       = fd_v;
      w[FMT_BRS_BIT]      = brs_v;
      w[FMT_ESI_BIT]      = esi_v;
      return w;
   endfunction
endpackage

// File: rtl/rxb_cmd_dec.sv
module rxb_cmd_dec
   import rxb_pkg::*;
(
   input  logic    meta_req,
   input  logic    data_req,
   input  logic    commit_req,
   input  logic    abort_req,
   output rxb_op_e op
);
   always_comb begin
      if (abort_req)       op = OP_ABORT;
      else if (commit_req) op = OP_COMMIT;
      else if (meta_req)   op = OP_META;
      else if (data_req)   op = OP_DATA;
      else                 op = OP_IDLE;
   end
endmodule

// File: rtl/rxb_ptr_ctrl.sv
module rxb_ptr_ctrl
   import rxb_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  rxb_op_e       op,
   input  logic          rd_req,
   output logic          wr_meta,
   output logic          wr_data,
   output logic [AW-1:0] wr_base,
   output logic [AW-1:0] rd_addr,
   output logic [PW-1:0] free_cnt,
   output logic [PW-1:0] pend_cnt,
   output logic [AW-1:0] raw_addr,
   output logic [AW-1:0] com_addr,
   output logic          ovr_flag
);
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] META_WORDS = PW'(2);

   logic [PW-1:0] raw_q, com_q, rd_q;
   logic          spoiled_q, ovr_q;
   logic          room_meta, room_data, drop, rd_go;

   assign free_cnt  = DEPTH_P - (raw_q - rd_q);
   assign pend_cnt  = com_q - rd_q;
   assign room_meta = free_cnt >= META_WORDS;
   assign room_data = free_cnt != '0;
   assign wr_meta   = (op == OP_META) && room_meta;
   assign wr_data   = (op == OP_DATA) && room_data;
   assign drop      = ((op == OP_META) && !room_meta) ||
                      ((op == OP_DATA) && !room_data);
   assign rd_go     = rd_req && (pend_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q     <= '0;
         com_q     <= '0;
         rd_q      <= '0;
         spoiled_q <= 1'b0;
         ovr_q     <= 1'b0;
      end else begin
         if (rd_go) rd_q <= rd_q + PW'(1);
         unique case (op)
            OP_ABORT: begin
               raw_q     <= com_q;
               spoiled_q <= 1'b0;
            end
            OP_COMMIT: begin
               if (spoiled_q) raw_q <= com_q;
               else           com_q <= raw_q;
               spoiled_q <= 1'b0;
            end
            OP_META: begin
               if (wr_meta) raw_q <= raw_q + META_WORDS;
            end
            OP_DATA: begin
               if (wr_data) raw_q <= raw_q + PW'(1);
            end
            default: ;
         endcase
         if (drop) begin
            spoiled_q <= 1'b1;
            ovr_q     <= 1'b1;
         end
      end
   end

   assign wr_base  = raw_q[AW-1:0];
   assign rd_addr  = rd_q[AW-1:0];
   assign raw_addr = raw_q[AW-1:0];
   assign com_addr = com_q[AW-1:0];
   assign ovr_flag = ovr_q;
endmodule

// File: rtl/rxb_word_store.sv
module rxb_word_store #(
   parameter int DEPTH = 32,
   parameter int WORD_W = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_meta,
   input  logic              wr_data,
   input  logic [AW-1:0]     wr_base,
   input  logic [WORD_W-1:0] fmt_word,
   input  logic [WORD_W-1:0] id_word,
   input  logic [WORD_W-1:0] pay_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     second_addr;
   logic [WORD_W-1:0] first_word;
   logic              first_we;

   assign second_addr = wr_base + AW'(1);
   assign first_we    = wr_meta || wr_data;
   assign first_word  = wr_meta ? fmt_word : pay_word;

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (first_we && wr_base == AW'(i))
                     mem[i] <= first_word;
                  else if (wr_meta && second_addr == AW'(i))
                     mem[i] <= id_word;
               end
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
               if (first_we && wr_base == AW'(i))
                  mem[i] <= first_word;
               else if (wr_meta && second_addr == AW'(i))
                  mem[i] <= id_word;
            end
         end
      end
   endgenerate

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
   import rxb_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          meta_store,
   input  logic [3:0]    dlc,
   input  logic          rtr,
   input  logic          ext_id,
   input  logic          fd_frame,
   input  logic          brs,
   input  logic          esi,
   input  logic [28:0]   ident,
   input  logic          data_store,
   input  logic [31:0]   data_word,
   input  logic          frame_commit,
   input  logic          frame_abort,
   input  logic          rd_strobe,
   output logic [31:0]   rd_word,
   output logic          rd_valid,
   output logic [AW:0]   free_words,
   output logic [AW:0]   pending_words,
   output logic [AW-1:0] raw_pos,
   output logic [AW-1:0] commit_pos,
   output logic [AW-1:0] read_pos,
   output logic          overrun
);
   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "rx_frame_buffer: DEPTH must be a power of two of at least 4");
   end

   rxb_op_e       op;
   logic          wr_meta, wr_data;
   logic [AW-1:0] wr_base, rd_addr;
   logic [31:0]   fmt_word, id_word;

   assign fmt_word = pack_format(dlc, rtr, ext_id, fd_frame, brs, esi);
   assign id_word  = {3'b000, ident};

   rxb_cmd_dec u_dec (
      .meta_req   (meta_store),
      .data_req   (data_store),
      .commit_req (frame_commit),
      .abort_req  (frame_abort),
      .op         (op)
   );

   rxb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .rd_req   (rd_strobe),
      .wr_meta  (wr_meta),
      .wr_data  (wr_data),
      .wr_base  (wr_base),
      .rd_addr  (rd_addr),
      .free_cnt (free_words),
      .pend_cnt (pending_words),
      .raw_addr (raw_pos),
      .com_addr (commit_pos),
      .ovr_flag (overrun)
   );

   rxb_word_store #(.DEPTH(DEPTH), .WORD_W(32), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_meta  (wr_meta),
      .wr_data  (wr_data),
      .wr_base  (wr_base),
      .fmt_word (fmt_word),
      .id_word  (id_word),
      .pay_word (data_word),
      .rd_addr  (rd_addr),
      .rd_word  (rd_word)
   );

   assign read_pos = rd_addr;
   assign rd_valid = pending_words != '0;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH)
)(
   input logic          clk,
   input logic          rst_n,
   input logic          meta_store,
   input logic          data_store,
   input logic          frame_commit,
   input logic          frame_abort,
   input logic          rd_strobe,
   input logic          rd_valid,
   input logic [AW:0]   free_words,
   input logic [AW:0]   pending_words,
   input logic [AW-1:0] raw_pos,
   input logic [AW-1:0] commit_pos,
   input logic [AW-1:0] read_pos,
   input logic          overrun
);
   // R6: counts never exceed the storage
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(free_words) + 32'(pending_words)) <= DEPTH);

   // R5: abort lands raw on the committed position, which stays put
   a_r5_abort_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      frame_abort |=> (raw_pos == $past(commit_pos)) && (commit_pos == $past(commit_pos)));

   // R4: a clean commit publishes the raw position
   a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && !frame_abort && !overrun) |=> commit_pos == $past(raw_pos));

   // R8: no movement of the read position while nothing is pending
   a_r8_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !rd_valid) |=> $stable(read_pos));

   // R8: one step per strobe while data is pending
   a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && rd_valid) |=> read_pos == AW'($past(read_pos) + AW'(1)));

   // R3: an accepted payload store moves raw by one
   a_r3_data_step: assert property (@(posedge clk) disable iff (!rst_n)
      (data_store && !meta_store && !frame_commit && !frame_abort && free_words != '0)
      |=> raw_pos == AW'($past(raw_pos) + AW'(1)));

   // R7: overrun is sticky
   a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
endmodule

bind rx_frame_buffer rxb_checker #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .meta_store    (meta_store),
   .data_store    (data_store),
   .frame_commit  (frame_commit),
   .frame_abort   (frame_abort),
   .rd_strobe     (rd_strobe),
   .rd_valid      (rd_valid),
   .free_words    (free_words),
   .pending_words (pending_words),
   .raw_pos       (raw_pos),
   .commit_pos    (commit_pos),
   .read_pos      (read_pos),
   .overrun       (overrun)
);

// File: tb/sim_rx_frame_buffer.sv
module sim_rx_frame_buffer;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int AW = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          meta_store = 1'b0;
   logic [3:0]    dlc = '0;
   logic          rtr = 1'b0, ext_id = 1'b0, fd_frame = 1'b0, brs = 1'b0, esi = 1'b0;
   logic [28:0]   ident = '0;
   logic          data_store = 1'b0;
   logic [31:0]   data_word = '0;
   logic          frame_commit = 1'b0, frame_abort = 1'b0, rd_strobe = 1'b0;
   logic [31:0]   rd_word;
   logic          rd_valid;
   logic [AW:0]   free_words, pending_words;
   logic [AW-1:0] raw_pos, commit_pos, read_pos;
   logic          overrun;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   localparam logic [31:0] FMT_EXP = 32'h0000_00EA;
   localparam logic [28:0] ID_VAL  = 29'h1ABC_DE12;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_frame_buffer #(.DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .meta_store(meta_store), .dlc(dlc), .rtr(rtr),
      .ext_id(ext_id), .fd_frame(fd_frame), .brs(brs), .esi(esi), .ident(ident),
      .data_store(data_store), .data_word(data_word), .frame_commit(frame_commit),
      .frame_abort(frame_abort), .rd_strobe(rd_strobe), .rd_word(rd_word),
      .rd_valid(rd_valid), .free_words(free_words), .pending_words(pending_words),
      .raw_pos(raw_pos), .commit_pos(commit_pos), .read_pos(read_pos), .overrun(overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   // one cycle of stimulus, starting and ending at a falling edge
   task automatic step(input logic m, input logic d, input logic [31:0] w,
                       input logic c, input logic a, input logic r);
      meta_store = m; data_store = d; data_word = w;
      frame_commit = c; frame_abort = a; rd_strobe = r;
      dlc = 4'hA; rtr = 1'b0; ext_id = 1'b1; fd_frame = 1'b1; brs = 1'b1; esi = 1'b0;
      ident = ID_VAL;
      @(negedge clk);
      meta_store = 0; data_store = 0; frame_commit = 0; frame_abort = 0; rd_strobe = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 raw", 32'(raw_pos), 0);
      chk("R1 commit", 32'(commit_pos), 0);
      chk("R1 read", 32'(read_pos), 0);
      chk("R1 free", 32'(free_words), DEPTH);
      chk("R1 pending", 32'(pending_words), 0);
      chk("R1 valid", 32'(rd_valid), 0);
      chk("R1 overrun", 32'(overrun), 0);
   endtask

   task automatic t_frame();
      step(1, 0, 0, 0, 0, 0);
      chk("R2 raw+2", 32'(raw_pos), 2);
      chk("R2 hidden", 32'(pending_words), 0);
      chk("R2 free", 32'(free_words), 6);
      step(0, 1, 32'hDEADBEEF, 0, 0, 0);
      chk("R3 raw+1", 32'(raw_pos), 3);
      step(0, 0, 0, 1, 0, 0);
      chk("R4 commit", 32'(commit_pos), 3);
      chk("R4 pending", 32'(pending_words), 3);
      chk("R4 valid", 32'(rd_valid), 1);
      chk("R2 format word", rd_word, FMT_EXP);
      step(0, 0, 0, 0, 0, 1);
      chk("R2 ident word", rd_word, {3'b000, ID_VAL});
      step(0, 0, 0, 0, 0, 1);
      chk("R3 data word", rd_word, 32'hDEADBEEF);
      step(0, 0, 0, 0, 0, 1);
      chk("R8 read pos", 32'(read_pos), 3);
      chk("R8 drained", 32'(rd_valid), 0);
      chk("R6 free", 32'(free_words), DEPTH);
   endtask

   task automatic t_read_empty();
      step(0, 0, 0, 0, 0, 1);
      chk("R8 empty strobe", 32'(read_pos), 3);
      chk("R8 empty pending", 32'(pending_words), 0);
   endtask

   task automatic t_abort();
      step(1, 0, 0, 0, 0, 0);
      step(0, 1, 32'h12345678, 0, 0, 0);
      chk("R5 before abort", 32'(raw_pos), 6);
      step(0, 0, 0, 0, 1, 0);
      chk("R5 raw rewound", 32'(raw_pos), 3);
      chk("R5 commit kept", 32'(commit_pos), 3);
      chk("R5 free restored", 32'(free_words), DEPTH);
      step(1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0);
      chk("R5 abort beats commit", 32'(commit_pos), 3);
      chk("R5 abort beats commit raw", 32'(raw_pos), 3);
      chk("R5 nothing pending", 32'(pending_words), 0);
   endtask

   task automatic t_collision();
      step(1, 1, 32'h11111111, 0, 0, 0);
      chk("R10 meta wins", 32'(raw_pos), 5);
      step(0, 1, 32'h22222222, 1, 0, 0);
      chk("R10 store with commit", 32'(raw_pos), 5);
      chk("R10 commit pos", 32'(commit_pos), 5);
      chk("R10 pending", 32'(pending_words), 2);
      chk("R10 format", rd_word, FMT_EXP);
      step(0, 0, 0, 0, 0, 1);
      chk("R10 ident not overwritten", rd_word, {3'b000, ID_VAL});
      step(0, 0, 0, 0, 0, 1);
      chk("R10 drained", 32'(read_pos), 5);
   endtask

   task automatic t_wrap();
      step(1, 0, 0, 0, 0, 0);
      step(0, 1, 32'hA0A0A0A0, 0, 0, 0);
      chk("R9 at end", 32'(raw_pos), 0);
      step(0, 1, 32'hB1B2B300, 0, 0, 0);
      chk("R9 wrapped raw", 32'(raw_pos), 1);
      step(0, 0, 0, 1, 0, 0);
      chk("R9 wrapped commit", 32'(commit_pos), 1);
      chk("R9 pending", 32'(pending_words), 4);
      step(0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 1);
      chk("R9 word at last slot", rd_word, 32'hA0A0A0A0);
      step(0, 0, 0, 0, 0, 1);
      chk("R9 word at slot 0", rd_word, 32'hB1B2B300);
      step(0, 0, 0, 0, 0, 1);
      chk("R9 read wrapped", 32'(read_pos), 1);
   endtask

   task automatic t_overrun();
      step(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(0, 1, 32'(i), 0, 0, 0);
      chk("R6 full", 32'(free_words), 0);
      chk("R7 no overrun yet", 32'(overrun), 0);
      step(0, 1, 32'hFFFF0000, 0, 0, 0);
      chk("R7 raw held", 32'(raw_pos), 1);
      chk("R7 overrun set", 32'(overrun), 1);
      step(0, 0, 0, 1, 0, 0);
      chk("R7 spoiled commit discards", 32'(pending_words), 0);
      chk("R7 free after discard", 32'(free_words), DEPTH);
      chk("R7 commit pos", 32'(commit_pos), 1);
      chk("R7 sticky", 32'(overrun), 1);
      step(0, 1, 32'h00000055, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      chk("R7 next frame commits", 32'(pending_words), 1);
      chk("R7 next frame word", rd_word, 32'h00000055);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_frame();
      t_read_empty();
      t_abort();
      t_collision();
      t_wrap();
      t_overrun();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule